// File: doc/BRIEF.md
# Multi-port receive push scheduler

This block is the physical-layer side source of a point-to-point packet receive bus. It keeps one byte-wide receive queue per port, decides which queue to serve in round-robin order, and pushes the chosen queue's data to the link device over a 32-bit word bus. The link device does not request transfers. It can only pause the bus.

Every transfer opens with one address cycle that names the port on the low byte of the bus. Packet words follow, marked with start, end, error and valid-byte information, plus an odd parity bit. A transfer closes at a packet end or when a programmable word budget is used up. An optional two-cycle idle gap can be placed between transfers. A queue takes part in arbitration only when its fill is above a programmable byte threshold, or when it holds at least one complete packet end.

The line side loads bytes one at a time through a simple write port that carries start, end and error markers. The port count must be a power of two and the queue depth a power of two of at least 4.

Top module: `rxq_push_sched`

## Requirements
- R1: While reset is held, rx_val, rx_sx, rx_sop, rx_eop, rx_err, rx_mod and rx_dat are all zero, and rx_par is 1.
- R2: A port is eligible when its stored byte count is strictly greater than cfg_thresh, or when it holds at least one byte marked as a packet end. A port with cfg_thresh bytes or fewer and no packet end gets no address cycle.
- R3: A transfer begins with exactly one address cycle. In that cycle rx_sx is 1 and rx_val is 0, the port number is on rx_dat[7:0], and rx_dat[31:8] is zero.
- R4: The search for the next port starts at the port after the one served last, wrapping around. The first eligible port found is served. After reset the search starts at port 0.
- R5: A transfer ends after the word that carries a packet end, or after cfg_burst data words (1 to 64, 4 bytes each), whichever comes first. A packet that remains is continued in a later transfer that opens with a new address cycle.
- R6: When lnk_pause is 1 at a rising edge, every rx_* output keeps its value across that edge, and no queue data is consumed.
- R7: If the served queue cannot form a word in mid-transfer (fewer than 4 bytes and no packet end), rx_val is 0 for those cycles. Once data arrives, the same port continues without a new address cycle.
- R8: The first byte of a word is on rx_dat[31:24], and the later bytes follow toward bit 0. Unused byte lanes are zero. On a word that carries a packet end, rx_mod gives the valid byte count: 00 = 4 bytes, 01 = 3 bytes (31:8), 10 = 2 bytes (31:16), 11 = 1 byte (31:24). On every other data word rx_mod is 00.
- R9: rx_err is 1 only on a word with rx_eop and rx_val both 1. It is 1 exactly when the written packet-end byte carried the error marker.
- R10: With cfg_gap2 = 0, the next address cycle may follow the last word of a transfer on the very next advancing cycle. With cfg_gap2 = 1, exactly two idle advancing cycles separate them.
- R11: In every cycle the number of ones in {rx_dat, rx_par} is odd. This holds on address cycles and on data cycles.
- R12: A 1-byte packet goes out as a single word with rx_sop and rx_eop both 1 and rx_mod = 11.
- R13: Bytes of two packets never share a word. A packet end closes the transfer, so the next packet from the same port comes after a fresh address cycle, with rx_sop set on its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Store one byte into a port queue |
| wr_port | input | PW | Queue that receives the byte |
| wr_byte | input | 8 | Byte value |
| wr_sop | input | 1 | Byte is the first of a packet |
| wr_eop | input | 1 | Byte is the last of a packet |
| wr_err | input | 1 | Packet is bad (meaningful with wr_eop) |
| cfg_thresh | input | CW | Fill threshold in bytes for eligibility |
| cfg_burst | input | BW | Word budget per transfer |
| cfg_gap2 | input | 1 | 1 inserts two idle cycles between transfers |
| lnk_pause | input | 1 | Registered hold request from the link |
| rx_dat | output | 32 | Port address or packet data |
| rx_mod | output | 2 | Valid byte code on a packet-end word |
| rx_sop | output | 1 | Word starts a packet |
| rx_eop | output | 1 | Word ends a packet |
| rx_err | output | 1 | Packet ends with an error |
| rx_val | output | 1 | rx_dat carries packet data |
| rx_sx | output | 1 | rx_dat carries a port address |
| rx_par | output | 1 | Odd parity over rx_dat |

## Verification
The line side can write a byte into the queue that the scheduler is draining in the same cycle that a word is taken from it. The fill count and packet-end count must then apply both changes at once. This case is provoked by loading a 20-byte packet one byte per cycle into the served port. Draining takes four bytes per word, so the queue keeps running dry while writes continue. The result is judged in three ways. The scoreboard receives every word intact and in order. The packet is delivered under a single address cycle. The monitor sees at least one cycle with valid low inside the transfer.

// File: rtl/rxq_push_sched.sv
module rxq_push_sched #(
  parameter int NPORT = 4,
  parameter int DEPTH = 64,
  parameter int MAXW  = 64,
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int BW = $clog2(MAXW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_port,
  input  logic [7:0]    wr_byte,
  input  logic          wr_sop,
  input  logic          wr_eop,
  input  logic          wr_err,
  input  logic [CW-1:0] cfg_thresh,
  input  logic [BW-1:0] cfg_burst,
  input  logic          cfg_gap2,
  input  logic          lnk_pause,
  output logic [31:0]   rx_dat,
  output logic [1:0]    rx_mod,
  output logic          rx_sop,
  output logic          rx_eop,
  output logic          rx_err,
  output logic          rx_val,
  output logic          rx_sx,
  output logic          rx_par
);

  localparam int AW = $clog2(DEPTH);
  localparam int IW = PW + AW;

  typedef enum logic [1:0] {S_SEL, S_DATA, S_GAP} st_t;

  logic [10:0]      mem  [2**IW];
  logic [AW-1:0]    wptr [NPORT];
  logic [AW-1:0]    rptr [NPORT];
  logic [CW-1:0]    cnt  [NPORT];
  logic [CW-1:0]    eopc [NPORT];
  logic [NPORT-1:0] elig, push_v, pop_v;

  st_t           st, n_st;
  logic [PW-1:0] cur, last, pick;
  logic [BW-1:0] wcnt;
  logic [1:0]    gap_left;
  logic          adv, any_elig, push, pop;
  logic          w_ready, w_eop, w_err;
  logic [2:0]    w_nb;
  logic [31:0]   w_dat, n_dat;
  logic [10:0]   ent [4];
  logic [1:0]    n_mod;
  logic          n_sop, n_eop, n_err, n_val, n_sx;

  assign adv  = !lnk_pause;
  assign push = wr_en && (cnt[wr_port] != CW'(DEPTH));

  always_ff @(posedge clk)
    if (push) mem[{wr_port, wptr[wr_port]}] <= {wr_sop, wr_eop, wr_err, wr_byte};

  always_comb
    for (int p = 0; p < NPORT; p++) begin
      push_v[p] = push && (wr_port == PW'(p));
      pop_v[p]  = pop && (cur == PW'(p));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int p = 0; p < NPORT; p++) begin
        wptr[p] <= '0;
        rptr[p] <= '0;
        cnt[p]  <= '0;
        eopc[p] <= '0;
      end
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (push_v[p]) wptr[p] <= wptr[p] + AW'(1);
        if (pop_v[p])  rptr[p] <= rptr[p] + AW'(w_nb);
        cnt[p]  <= cnt[p] + CW'(push_v[p]) - (pop_v[p] ? CW'(w_nb) : CW'(0));
        eopc[p] <= eopc[p] + CW'(push_v[p] & wr_eop) - CW'(pop_v[p] & w_eop);
      end
    end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign elig[p] = (cnt[p] > cfg_thresh) || (eopc[p] != '0);

    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[p] <= CW'(DEPTH)) && (eopc[p] <= cnt[p]));
  end

  always_comb begin
    any_elig = 1'b0;
    pick     = last;
    for (int i = 1; i <= NPORT; i++)
      if (!any_elig && elig[PW'((int'(last) + i) % NPORT)]) begin
        any_elig = 1'b1;
        pick     = PW'((int'(last) + i) % NPORT);
      end
  end

  always_comb begin
    w_eop = 1'b0;
    w_err = 1'b0;
    w_nb  = 3'd4;
    w_dat = '0;
    for (int i = 0; i < 4; i++) begin
      ent[i] = mem[{cur, rptr[cur] + AW'(i)}];
      if (!w_eop && (CW'(i) < cnt[cur]) && ent[i][9]) begin
        w_eop = 1'b1;
        w_err = ent[i][8];
        w_nb  = 3'(i + 1);
      end
    end
    w_ready = w_eop || (cnt[cur] >= CW'(4));
    for (int i = 0; i < 4; i++)
      if (3'(i) < w_nb) w_dat[8*(3-i) +: 8] = ent[i][7:0];
  end

  always_comb begin
    n_st  = st;
    n_dat = '0;
    n_mod = '0;
    n_sop = 1'b0;
    n_eop = 1'b0;
    n_err = 1'b0;
    n_val = 1'b0;
    n_sx  = 1'b0;
    pop   = 1'b0;
    case (st)
      S_SEL:
        if (any_elig) begin
          n_sx  = 1'b1;
          n_dat = 32'(pick);
          n_st  = S_DATA;
        end
      S_DATA:
        if (w_ready) begin
          pop   = adv;
          n_val = 1'b1;
          n_dat = w_dat;
          n_mod = 2'(3'd4 - w_nb);
          n_sop = ent[0][10];
          n_eop = w_eop;
          n_err = w_err;
          if (w_eop || (wcnt + BW'(1) >= cfg_burst))
            n_st = cfg_gap2 ? S_GAP : S_SEL;
        end
      S_GAP:
        if (gap_left == 2'd1) n_st = S_SEL;
      default: n_st = S_SEL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_SEL;
      cur      <= '0;
      last     <= PW'(NPORT - 1);
      wcnt     <= '0;
      gap_left <= 2'd2;
      rx_dat   <= '0;
      rx_mod   <= '0;
      rx_sop   <= 1'b0;
      rx_eop   <= 1'b0;
      rx_err   <= 1'b0;
      rx_val   <= 1'b0;
      rx_sx    <= 1'b0;
      rx_par   <= 1'b1;
    end else if (adv) begin
      st       <= n_st;
      rx_dat   <= n_dat;
      rx_mod   <= n_mod;
      rx_sop   <= n_sop;
      rx_eop   <= n_eop;
      rx_err   <= n_err;
      rx_val   <= n_val;
      rx_sx    <= n_sx;
      rx_par   <= ~^n_dat;
      gap_left <= (st == S_GAP) ? gap_left - 2'd1 : 2'd2;
      if (st == S_SEL && any_elig) begin
        cur  <= pick;
        last <= pick;
        wcnt <= '0;
      end else if (st == S_DATA && w_ready) begin
        wcnt <= wcnt + BW'(1);
      end
    end

  a_r6_hold_when_paused: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_pause |=> $stable({rx_dat, rx_mod, rx_sop, rx_eop, rx_err, rx_val, rx_sx, rx_par}));

  a_r3_addr_shape: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sx |-> (!rx_val && rx_dat[31:8] == 24'h0));

  a_r3_addr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sx && !lnk_pause) |=> !rx_sx);

  a_r5_eop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_val && rx_eop && !lnk_pause) |=> !rx_val);

  a_r8_mod_zero_midpacket: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_val && !rx_eop) |-> (rx_mod == 2'b00));

  a_r9_err_needs_eop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> (rx_eop && rx_val));

  a_r12_sop_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sop |-> rx_val);

endmodule

// File: tb/rxq_push_sched_tb.sv
module rxq_push_sched_tb_top;
  localparam int CLK_NS = 10;
  localparam int NP = 4;

  typedef logic [36:0] wrd_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_port = '0;
  logic [7:0]  wr_byte = '0;
  logic        wr_sop = 1'b0, wr_eop = 1'b0, wr_err = 1'b0;
  logic [6:0]  cfg_thresh = 7'd8;
  logic [6:0]  cfg_burst = 7'd64;
  logic        cfg_gap2 = 1'b0;
  logic        lnk_pause = 1'b0;
  logic [31:0] rx_dat;
  logic [1:0]  rx_mod;
  logic        rx_sop, rx_eop, rx_err, rx_val, rx_sx, rx_par;

  always #(CLK_NS/2) clk = ~clk;

  rxq_push_sched dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port), .wr_byte(wr_byte),
    .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_err(wr_err), .cfg_thresh(cfg_thresh),
    .cfg_burst(cfg_burst), .cfg_gap2(cfg_gap2), .lnk_pause(lnk_pause),
    .rx_dat(rx_dat), .rx_mod(rx_mod), .rx_sop(rx_sop), .rx_eop(rx_eop),
    .rx_err(rx_err), .rx_val(rx_val), .rx_sx(rx_sx), .rx_par(rx_par)
  );

  int   n_chk = 0, n_bad = 0;
  bit   done = 0;
  wrd_t expq [NP][$];
  int   addr_log[$];
  int   gap_log[$];
  int   addr_mark = 0;
  int   idle_run = 0, stall_cnt = 0, hold_cnt = 0, cur_p = 0;
  bit   in_mid = 0, mon_on = 0, pause_chk = 0;
  logic adv_seen = 1'b0;
  logic [39:0] obs, snap;
  wrd_t got, e;

  function automatic void chk(input bit ok, input string req, input string what,
                              input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endfunction

  function automatic int pending();
    int s = 0;
    for (int p = 0; p < NP; p++) s += expq[p].size();
    return s;
  endfunction

  always @(posedge clk) adv_seen <= !lnk_pause;

  // scoreboard monitor: pops per-port expected words as the bus produces them
  always @(negedge clk) if (mon_on) begin
    obs = {rx_dat, rx_mod, rx_sop, rx_eop, rx_err, rx_val, rx_sx, rx_par};
    if (!adv_seen) begin
      if (pause_chk) begin
        hold_cnt++;
        chk(obs == snap, "R6", "outputs moved while paused", obs, snap);
      end
    end else begin
      chk(^{rx_dat, rx_par} == 1'b1, "R11", "odd parity", {rx_dat, rx_par}, 0);
      if (rx_sx) begin
        chk(!rx_val && rx_dat[31:8] == 24'h0, "R3", "address cycle shape",
            {rx_val, rx_dat}, rx_dat[7:0]);
        addr_log.push_back(int'(rx_dat[7:0]));
        gap_log.push_back(idle_run);
        idle_run = 0;
        cur_p = int'(rx_dat[7:0]);
        in_mid = 1;
      end else if (rx_val) begin
        got = {rx_dat, rx_mod, rx_sop, rx_eop, rx_err};
        if (cur_p >= NP || expq[cur_p].size() == 0)
          chk(0, "R8", "unexpected word", got, 0);
        else begin
          e = expq[cur_p].pop_front();
          chk(got == e, "R8/R9/R12/R13", "word {dat,mod,sop,eop,err}", got, e);
        end
        idle_run = 0;
        in_mid = !rx_eop;
      end else begin
        idle_run++;
        if (in_mid) stall_cnt++;
      end
    end
    snap = obs;
  end

  // driver: writes one packet byte per cycle and predicts its bus words
  task automatic wr_pkt(input int port, input int len, input bit err, input int seed,
                        input int stop_at);
    logic [31:0] d = '0;
    int nb = 0;
    for (int i = 0; i < len; i++) begin
      if (i == stop_at) begin
        @(negedge clk);
        wr_en = 1'b0;
        repeat (20) @(negedge clk);
        // R2: stop_at bytes equal to the threshold, no packet end -> no address
        chk(addr_log.size() == addr_mark, "R2", "address below threshold",
            addr_log.size(), addr_mark);
      end
      @(negedge clk);
      wr_en   = 1'b1;
      wr_port = 2'(port);
      wr_byte = 8'(seed + i);
      wr_sop  = (i == 0);
      wr_eop  = (i == len - 1);
      wr_err  = err && (i == len - 1);
      d[8*(3-nb) +: 8] = 8'(seed + i);
      nb++;
      if (nb == 4 || i == len - 1) begin
        expq[port].push_back({d, 2'(4 - nb), i < 4, i == len - 1, err && (i == len - 1)});
        d = '0;
        nb = 0;
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (pending() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    int n0, s0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(rx_val == 0 && rx_sx == 0, "R1", "val/sx in reset", {rx_val, rx_sx}, 0);
    chk(rx_dat == 0 && rx_mod == 0 && {rx_sop, rx_eop, rx_err} == 0, "R1", "data in reset",
        {rx_dat, rx_mod, rx_sop, rx_eop, rx_err}, 0);
    chk(rx_par == 1'b1, "R1", "parity in reset", rx_par, 1);
    rst_n = 1'b1;
    @(negedge clk);
    snap = {rx_dat, rx_mod, rx_sop, rx_eop, rx_err, rx_val, rx_sx, rx_par};
    mon_on = 1;

    // R12 + R2 via packet end: a single-byte packet on port 2
    wr_pkt(2, 1, 0, 'h10, -1);
    drain();
    chk(addr_log.size() == 1 && addr_log[0] == 2, "R12", "single byte served on port 2",
        addr_log.size() > 0 ? addr_log[0] : -1, 2);

    // R2 threshold and R7 underrun: trickle 20 bytes into port 1
    addr_mark = addr_log.size();
    s0 = stall_cnt;
    wr_pkt(1, 20, 0, 'h20, 8);
    drain();
    chk(addr_log.size() == addr_mark + 1, "R7", "one address for trickled packet",
        addr_log.size() - addr_mark, 1);
    chk(addr_log[$] == 1, "R2", "port above threshold served", addr_log[$], 1);
    chk(stall_cnt > s0, "R7", "valid dropped mid-transfer", stall_cnt - s0, 1);

    // R4 round robin from the port after the last served (1) and R10 gap 0
    lnk_pause = 1'b1;
    wr_pkt(3, 6, 0, 'h30, -1);
    wr_pkt(0, 5, 0, 'h40, -1);
    wr_pkt(1, 7, 0, 'h50, -1);
    n0 = addr_log.size();
    lnk_pause = 1'b0;
    drain();
    chk(addr_log.size() == n0 + 3, "R4", "transfer count", addr_log.size() - n0, 3);
    if (addr_log.size() == n0 + 3) begin
      chk(addr_log[n0] == 3, "R4", "first pick", addr_log[n0], 3);
      chk(addr_log[n0+1] == 0, "R4", "second pick", addr_log[n0+1], 0);
      chk(addr_log[n0+2] == 1, "R4", "third pick", addr_log[n0+2], 1);
      chk(gap_log[n0+1] == 0 && gap_log[n0+2] == 0, "R10", "gap 0 idle cycles",
          gap_log[n0+1] + gap_log[n0+2], 0);
    end

    // R10 gap 2, R9 error, R13 packet boundary closes transfer
    cfg_gap2 = 1'b1;
    lnk_pause = 1'b1;
    wr_pkt(2, 5, 1, 'h60, -1);
    wr_pkt(2, 3, 0, 'h70, -1);
    wr_pkt(3, 4, 0, 'h80, -1);
    n0 = addr_log.size();
    lnk_pause = 1'b0;
    drain();
    chk(addr_log.size() == n0 + 3, "R13", "second packet needs new transfer",
        addr_log.size() - n0, 3);
    if (addr_log.size() == n0 + 3) begin
      chk(addr_log[n0] == 2 && addr_log[n0+1] == 3 && addr_log[n0+2] == 2, "R13",
          "order 2,3,2", addr_log[n0] * 256 + addr_log[n0+1] * 16 + addr_log[n0+2], 'h232);
      chk(gap_log[n0+1] == 2, "R10", "gap 2 first", gap_log[n0+1], 2);
      chk(gap_log[n0+2] == 2, "R10", "gap 2 second", gap_log[n0+2], 2);
    end
    cfg_gap2 = 1'b0;

    // R5 word budget: 20 bytes, 2 words per transfer -> 3 transfers on port 0
    cfg_burst = 7'd2;
    lnk_pause = 1'b1;
    wr_pkt(0, 20, 0, 'h90, -1);
    n0 = addr_log.size();
    lnk_pause = 1'b0;
    drain();
    chk(addr_log.size() == n0 + 3, "R5", "sections for 5 words", addr_log.size() - n0, 3);
    for (int k = n0; k < addr_log.size(); k++)
      chk(addr_log[k] == 0, "R5", "section port", addr_log[k], 0);
    cfg_burst = 7'd64;

    // R6 pause in the middle of a transfer
    lnk_pause = 1'b1;
    wr_pkt(1, 40, 0, 'hA0, -1);
    lnk_pause = 1'b0;
    repeat (3) @(negedge clk);
    pause_chk = 1;
    lnk_pause = 1'b1;
    repeat (4) @(negedge clk);
    lnk_pause = 1'b0;
    pause_chk = 0;
    drain();
    chk(hold_cnt >= 3, "R6", "hold cycles observed", hold_cnt, 3);

    chk(pending() == 0, "R8", "all words delivered", pending(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R5 watchdog expired act=%0d exp=%0d", 50000, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule